// File: doc/BRIEF.md
# Dual J/K-bar Flip-Flop with Asynchronous Set and Clear

This block holds a parameterized number of independent storage channels. The default is two. Each channel is a rising-edge flip-flop steered by a J input and an active-low K input (K-bar). Each channel has its own clock, an active-low asynchronous set and an active-low asynchronous clear. Each channel drives a true output and a complementary output.

On a rising clock edge the J/K-bar pair chooses one of four actions: keep, invert, store one or store zero. Tying J and K-bar together turns a channel into a plain D flip-flop. The asynchronous inputs act without a clock. When both are held low, both outputs go high at once. When they are released from that condition, the stored value is decided by which input was released last.

The block is used wherever a small group of independent flops is needed, each with a toggle or load choice per edge and with forced initialisation.

Top module: `jkb_dual_ff`

## Requirements
- R1: Channels are independent: clocking, loading, setting or clearing channel c changes only bit c of q_o and qb_o.
- R2: With set_ni[c]=0 and rst_ni[c]=1, q_o[c]=1 and qb_o[c]=0 at once, with no clock edge.
- R3: With rst_ni[c]=0 and set_ni[c]=1, q_o[c]=0 and qb_o[c]=1 at once, with no clock edge.
- R4: With set_ni[c]=0 and rst_ni[c]=0, q_o[c]=1 and qb_o[c]=1.
- R5: When neither asynchronous input is low, qb_o[c] is the inverse of q_o[c].
- R6: A rising edge with j_i=1 and kb_i=0 inverts the stored value.
- R7: A rising edge with j_i=1 and kb_i=1 stores one. A rising edge with j_i=0 and kb_i=0 stores zero.
- R8: A rising edge with j_i=0 and kb_i=1 keeps the stored value.
- R9: With j_i[c] equal to kb_i[c], q_o[c] takes the value of j_i[c] after each rising edge.
- R10: On release from the both-low condition, the input released last decides the value: clear released last gives 0, set released last gives 1. A release of both in the same instant gives 1.
- R11: A rising edge that occurs while either asynchronous input is low does not change the value left after release.
- R12: The stored value changes only at a rising edge, using j_i/kb_i as they are at that edge. Falling edges, and input changes while the clock is high, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | NUM_CH | Per-channel clock, rising edge active |
| j_i | input | NUM_CH | Per-channel J input |
| kb_i | input | NUM_CH | Per-channel active-low K input |
| set_ni | input | NUM_CH | Per-channel asynchronous set, active low |
| rst_ni | input | NUM_CH | Per-channel asynchronous clear, active low |
| q_o | output | NUM_CH | True output, bit c belongs to channel c |
| qb_o | output | NUM_CH | Complementary output, bit c belongs to channel c |

## Verification
The hardest state to reach is leaving the both-low condition. The outcome depends only on release order, and the outputs show nothing of it while both inputs are still low. The stimulus releases set and clear in each of the three orders: clear last, set last, and both in one assignment. Before each release it loads the opposite value, so the result cannot be a leftover. It also applies a J/K-bar load edge while an asynchronous input is held low. The value is then read only after release.

// File: rtl/jkb_pkg.sv
package jkb_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_FLIP = 2'b01,
    ACT_ONE  = 2'b10,
    ACT_ZERO = 2'b11
  } jk_act_e;
endpackage

// File: rtl/jkb_decode.sv
module jkb_decode
  import jkb_pkg::*;
(
  input  logic    j_i,
  input  logic    kb_i,
  output jk_act_e act_o
);
  always_comb begin
    unique case ({j_i, kb_i})
      2'b10:   act_o = ACT_FLIP;
      2'b11:   act_o = ACT_ONE;
      2'b00:   act_o = ACT_ZERO;
      default: act_o = ACT_KEEP;
    endcase
  end
endmodule

// File: rtl/jkb_outmux.sv
module jkb_outmux (
  input  logic set_ni,
  input  logic rst_ni,
  input  logic state_i,
  output logic q_o,
  output logic qb_o
);
  // each output is forced high by its own async input; both low -> both high
  assign q_o  = ~set_ni | (rst_ni & state_i);
  assign qb_o = ~rst_ni | (set_ni & ~state_i);
endmodule

// File: rtl/jkb_channel.sv
module jkb_channel
  import jkb_pkg::*;
(
  input  logic clk_i,
  input  logic j_i,
  input  logic kb_i,
  input  logic set_ni,
  input  logic rst_ni,
  output logic q_o,
  output logic qb_o
);
  logic    set_only, rst_only, both_on;
  logic    state_q;
  jk_act_e act;

  assign set_only = ~set_ni & rst_ni;
  assign rst_only = ~rst_ni & set_ni;
  assign both_on  = ~set_ni & ~rst_ni;

  jkb_decode i_dec (
    .j_i   (j_i),
    .kb_i  (kb_i),
    .act_o (act)
  );

  // entering both-low presets one; leaving it re-fires whichever single input remains
  always_ff @(posedge clk_i or posedge rst_only or posedge set_only or posedge both_on) begin
    if (rst_only) begin
      state_q <= 1'b0;
    end else if (set_only || both_on) begin
      state_q <= 1'b1;
    end else begin
      unique case (act)
        ACT_FLIP: state_q <= ~state_q;
        ACT_ONE:  state_q <= 1'b1;
        ACT_ZERO: state_q <= 1'b0;
        default:  state_q <= state_q;
      endcase
    end
  end

  jkb_outmux i_out (
    .set_ni  (set_ni),
    .rst_ni  (rst_ni),
    .state_i (state_q),
    .q_o     (q_o),
    .qb_o    (qb_o)
  );
endmodule

// File: rtl/jkb_dual_ff.sv
module jkb_dual_ff #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] clk_i,
  input  logic [NUM_CH-1:0] j_i,
  input  logic [NUM_CH-1:0] kb_i,
  input  logic [NUM_CH-1:0] set_ni,
  input  logic [NUM_CH-1:0] rst_ni,
  output logic [NUM_CH-1:0] q_o,
  output logic [NUM_CH-1:0] qb_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    jkb_channel i_ch (
      .clk_i  (clk_i[g]),
      .j_i    (j_i[g]),
      .kb_i   (kb_i[g]),
      .set_ni (set_ni[g]),
      .rst_ni (rst_ni[g]),
      .q_o    (q_o[g]),
      .qb_o   (qb_o[g])
    );
  end
endmodule

// File: rtl/jkb_dual_ff_chk.sv
module jkb_dual_ff_chk #(
  parameter int NUM_CH = 2
) (
  input logic [NUM_CH-1:0] clk_i,
  input logic [NUM_CH-1:0] j_i,
  input logic [NUM_CH-1:0] kb_i,
  input logic [NUM_CH-1:0] set_ni,
  input logic [NUM_CH-1:0] rst_ni,
  input logic [NUM_CH-1:0] q_o,
  input logic [NUM_CH-1:0] qb_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic armed_q;
    // armed: the previous edge of this channel was synchronous and no async input has fired since
    always_ff @(posedge clk_i[g] or negedge set_ni[g] or negedge rst_ni[g]) begin
      if (!set_ni[g] || !rst_ni[g]) armed_q <= 1'b0;
      else                          armed_q <= 1'b1;
    end

    // R2
    set_force_chk: assert property (@(posedge clk_i[g])
      (!set_ni[g] && rst_ni[g]) |-> (q_o[g] && !qb_o[g]));
    // R3
    clr_force_chk: assert property (@(posedge clk_i[g])
      (set_ni[g] && !rst_ni[g]) |-> (!q_o[g] && qb_o[g]));
    // R4
    both_high_chk: assert property (@(posedge clk_i[g])
      (!set_ni[g] && !rst_ni[g]) |-> (q_o[g] && qb_o[g]));
    // R5
    compl_chk: assert property (@(posedge clk_i[g])
      (set_ni[g] && rst_ni[g]) |-> (qb_o[g] == !q_o[g]));
    // R6
    flip_chk: assert property (@(posedge clk_i[g]) disable iff (!set_ni[g] || !rst_ni[g])
      (armed_q && $past(j_i[g]) && !$past(kb_i[g])) |-> (q_o[g] == !$past(q_o[g])));
    // R7
    load_chk: assert property (@(posedge clk_i[g]) disable iff (!set_ni[g] || !rst_ni[g])
      (armed_q && ($past(j_i[g]) == $past(kb_i[g]))) |-> (q_o[g] == $past(j_i[g])));
    // R8
    keep_chk: assert property (@(posedge clk_i[g]) disable iff (!set_ni[g] || !rst_ni[g])
      (armed_q && !$past(j_i[g]) && $past(kb_i[g])) |-> $stable(q_o[g]));
  end
endmodule

bind jkb_dual_ff jkb_dual_ff_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i  (clk_i),
  .j_i    (j_i),
  .kb_i   (kb_i),
  .set_ni (set_ni),
  .rst_ni (rst_ni),
  .q_o    (q_o),
  .qb_o   (qb_o)
);

// File: tb/test_jkb_dual_ff.sv
`timescale 1ns/1ps
module test_jkb_dual_ff;
  localparam int N = 2;
  localparam int WD_LIMIT = 100000;

  logic         clk = 1'b0;
  logic [N-1:0] clk_i = '0;
  logic [N-1:0] j_i = '0;
  logic [N-1:0] kb_i = '1;
  logic [N-1:0] set_ni = '1;
  logic [N-1:0] rst_ni = '0;
  logic [N-1:0] q_o, qb_o;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  jkb_dual_ff #(.NUM_CH(N)) i_jkb_dual_ff (
    .clk_i(clk_i), .j_i(j_i), .kb_i(kb_i), .set_ni(set_ni),
    .rst_ni(rst_ni), .q_o(q_o), .qb_o(qb_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected <=%0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input int c, input string req, input logic eq, input logic eqb);
    checks++;
    if (q_o[c] !== eq || qb_o[c] !== eqb) begin
      errors++;
      $display("FAIL %s ch%0d: actual q=%b qb=%b expected q=%b qb=%b", req, c, q_o[c], qb_o[c], eq, eqb);
    end
  endtask

  task automatic pulse(input int c, input logic j, input logic kb);
    j_i[c] = j; kb_i[c] = kb;
    #2.5 clk_i[c] = 1'b1;
    #2.5 clk_i[c] = 1'b0;
    #1;
  endtask

  task automatic t_reset_state;
    #3;
    for (int c = 0; c < N; c++) chk(c, "R3", 1'b0, 1'b1);
    rst_ni = '1;
    #1;
    for (int c = 0; c < N; c++) chk(c, "R5", 1'b0, 1'b1);
  endtask

  task automatic t_set;
    set_ni[0] = 1'b0; #1;
    chk(0, "R2", 1'b1, 1'b0);
    chk(1, "R1", 1'b0, 1'b1);
    set_ni[0] = 1'b1; #1;
    chk(0, "R5", 1'b1, 1'b0);
  endtask

  task automatic t_jk_modes;
    // ch0 holds 1 on entry
    pulse(0, 1'b1, 1'b0); chk(0, "R6", 1'b0, 1'b1);
    pulse(0, 1'b1, 1'b0); chk(0, "R6", 1'b1, 1'b0);
    pulse(0, 1'b0, 1'b0); chk(0, "R7", 1'b0, 1'b1);
    pulse(0, 1'b1, 1'b1); chk(0, "R7", 1'b1, 1'b0);
    pulse(0, 1'b0, 1'b1); chk(0, "R8", 1'b1, 1'b0);
    chk(1, "R1", 1'b0, 1'b1);
    pulse(1, 1'b0, 1'b1); chk(1, "R8", 1'b0, 1'b1);
    chk(0, "R1", 1'b1, 1'b0);
  endtask

  task automatic t_edge_only;
    // ch0 holds 1: keep at rise, switch to flip while high, then fall
    j_i[0] = 1'b0; kb_i[0] = 1'b1;
    #2.5 clk_i[0] = 1'b1;
    #1 j_i[0] = 1'b1; kb_i[0] = 1'b0;
    #1 chk(0, "R12", 1'b1, 1'b0);
    #0.5 clk_i[0] = 1'b0;
    #1 chk(0, "R12", 1'b1, 1'b0);
    j_i[0] = 1'b0; kb_i[0] = 1'b0;
    #3 chk(0, "R12", 1'b1, 1'b0);
  endtask

  task automatic t_tied;
    logic seq [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    for (int i = 0; i < 4; i++) begin
      pulse(1, seq[i], seq[i]);
      chk(1, "R9", seq[i], ~seq[i]);
    end
  endtask

  task automatic t_both;
    pulse(1, 1'b1, 1'b1);
    {set_ni[1], rst_ni[1]} = 2'b00; #1;
    chk(1, "R4", 1'b1, 1'b1);
    chk(0, "R1", 1'b1, 1'b0);
    set_ni[1] = 1'b1; #1;
    chk(1, "R3", 1'b0, 1'b1);
    rst_ni[1] = 1'b1; #1;
    chk(1, "R10", 1'b0, 1'b1);
    {set_ni[1], rst_ni[1]} = 2'b00; #1;
    chk(1, "R4", 1'b1, 1'b1);
    rst_ni[1] = 1'b1; #1;
    chk(1, "R2", 1'b1, 1'b0);
    set_ni[1] = 1'b1; #1;
    chk(1, "R10", 1'b1, 1'b0);
    pulse(1, 1'b0, 1'b0);
    chk(1, "R7", 1'b0, 1'b1);
    {set_ni[1], rst_ni[1]} = 2'b00; #1;
    {set_ni[1], rst_ni[1]} = 2'b11; #1;
    chk(1, "R10", 1'b1, 1'b0);
  endtask

  task automatic t_async_clock;
    // ch0 holds 1
    rst_ni[0] = 1'b0; #1;
    pulse(0, 1'b1, 1'b1);
    chk(0, "R3", 1'b0, 1'b1);
    rst_ni[0] = 1'b1; #1;
    chk(0, "R11", 1'b0, 1'b1);
    set_ni[0] = 1'b0; #1;
    pulse(0, 1'b0, 1'b0);
    pulse(0, 1'b1, 1'b0);
    set_ni[0] = 1'b1; #1;
    chk(0, "R11", 1'b1, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_set();
    t_jk_modes();
    t_edge_only();
    t_tied();
    t_both();
    t_async_clock();
    #10;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule